// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the architectural registers of a 32-bit processor core that has several operating modes. Instructions name a register with a 4-bit index. The block turns that index and the current operating mode into one of 31 physical general-purpose registers. Low registers and the program counter are common to all modes. The fast-interrupt mode has its own copies of the upper working registers. Every exception mode has its own stack-pointer and link registers. Two combinational read ports and one clocked write port serve the datapath. A read of index 15 returns the stored program counter plus an offset that the caller supplies on `pc_offset`. That offset is the read-ahead for the current instruction-set state.

The block also holds the current status word and five saved-status words, one for each exception mode. The low five bits of the current status word are the mode field. A registered copy of the decoded bank is the block's state machine, with states BANK_USR, BANK_FIQ, BANK_IRQ, BANK_SVC, BANK_ABT and BANK_UND. After reset the state is BANK_SVC. In every cycle where `cpsr_we` is high, the state moves to the bank that `cpsr_wdata[4:0]` decodes to, including a move to its own bank. With no write it stays where it is. The mode codes are user and system into BANK_USR, fast interrupt into BANK_FIQ, interrupt into BANK_IRQ, supervisor into BANK_SVC, abort into BANK_ABT and undefined into BANK_UND. Any other code also goes to BANK_USR.

To enter an exception, the caller pulses `exc_enter` with the target mode on `exc_mode`. The block copies the status word into that mode's saved-status register. The caller normally writes the new status word in the same cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset, all 31 general registers and all five saved-status registers read as zero, and `cpsr_q` is 0x00000013 (supervisor mode).
- R2: Indices 0 to 7 name one physical set. A value written in any mode reads back unchanged in every other mode.
- R3: In fast-interrupt mode (mode bits 10001), indices 8 to 14 reach seven private registers. Every other mode shares one common copy of indices 8 to 12.
- R4: Supervisor (10011), abort (10111), interrupt (10010) and undefined (11011) modes each own a private index 13 and index 14. User (10000), system (11111) and any unrecognised code share one pair.
- R5: Index 15 is one program counter for all modes. A write to index 15 sets it. A read of index 15 returns the stored value plus `pc_offset`, modulo 2^32.
- R6: `spsr_rdata` shows the saved-status register of the current exception mode, and `spsr_we` writes it at the next edge.
- R7: In user, system or unrecognised modes, `spsr_rdata` reads zero and `spsr_we` changes no saved-status register.
- R8: When `exc_enter` is high and `exc_mode` is an exception mode, that mode's saved-status register takes the `cpsr_q` value from before the edge. A `cpsr_we` in the same cycle still updates the status word. The snapshot wins over an `spsr_we` aimed at the same register. Any other `exc_mode` code snapshots nothing.
- R9: A read in the same cycle as a write to the same physical register returns the written data, plus `pc_offset` for index 15. `spsr_rdata` likewise returns the snapshot value or `spsr_wdata` in the cycle it is written.
- R10: `cpsr_we` loads `cpsr_q` at the next edge. Reads and writes in the same cycle use the mode held before that edge.
- R11: The two read ports are independent, and equal indices give equal data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Register index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Register index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data |
| pc_offset | input | 32 | Read-ahead added on index 15 reads |
| cpsr_we | input | 1 | Status word write enable |
| cpsr_wdata | input | 32 | New status word |
| cpsr_q | output | 32 | Current status word |
| spsr_we | input | 1 | Saved-status write enable for the current mode |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_rdata | output | 32 | Saved-status word of the current mode |
| exc_enter | input | 1 | Exception entry snapshot strobe |
| exc_mode | input | 5 | Mode code being entered |

## Verification
The bench attacks the cycle in which the mode changes. A write in the same cycle as a status update must land in the old bank. A design that used the new mode would corrupt the wrong stack pointer. The bench also fires an exception snapshot together with a status write and a saved-status write. A wrong priority would save the new status word, or let the explicit write overwrite the saved one. Further checks hit unrecognised mode codes, which must behave as user mode, and saved-status writes from user mode, which a loose design would store. Same-cycle bypass on index 15 must still add the read-ahead offset.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int IDX_W     = 4;
    localparam int MODE_W    = 5;
    localparam int NUM_PHYS  = 31;
    localparam int PHYS_W    = $clog2(NUM_PHYS);
    localparam int NUM_SAVED = 5;
    localparam int SLOT_W    = $clog2(NUM_SAVED);
    localparam int NUM_RD    = 2;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    localparam logic [IDX_W-1:0] PC_IDX = 4'd15;

    typedef enum logic [2:0] {
        BANK_USR,
        BANK_FIQ,
        BANK_IRQ,
        BANK_SVC,
        BANK_ABT,
        BANK_UND
    } bank_e;

    function automatic bank_e decode_bank(input logic [MODE_W-1:0] m);
        bank_e b;
        unique case (m)
            MODE_FIQ: b = BANK_FIQ;
            MODE_IRQ: b = BANK_IRQ;
            MODE_SVC: b = BANK_SVC;
            MODE_ABT: b = BANK_ABT;
            MODE_UND: b = BANK_UND;
            default:  b = BANK_USR;
        endcase
        return b;
    endfunction

    function automatic logic has_saved(input bank_e b);
        return (b != BANK_USR);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input bank_e b);
        logic [SLOT_W-1:0] s;
        unique case (b)
            BANK_FIQ: s = 3'd0;
            BANK_IRQ: s = 3'd1;
            BANK_SVC: s = 3'd2;
            BANK_ABT: s = 3'd3;
            BANK_UND: s = 3'd4;
            default:  s = 3'd0;
        endcase
        return s;
    endfunction

    // Physical layout: 0-7 low, 8-12 common high, 13-14 user pair, 15 PC,
    // 16-22 fast-interrupt 8..14, then pairs for svc, abt, irq, und.
    function automatic logic [PHYS_W-1:0] phys_of(input bank_e b,
                                                  input logic [IDX_W-1:0] idx);
        logic [PHYS_W-1:0] i5;
        logic [PHYS_W-1:0] p;
        i5 = {1'b0, idx};
        if (idx < 4'd8 || idx == PC_IDX) begin
            p = i5;
        end else if (b == BANK_FIQ) begin
            p = i5 + 5'd8;
        end else if (idx < 4'd13) begin
            p = i5;
        end else begin
            unique case (b)
                BANK_SVC: p = i5 + 5'd10;
                BANK_ABT: p = i5 + 5'd12;
                BANK_IRQ: p = i5 + 5'd14;
                BANK_UND: p = i5 + 5'd16;
                default:  p = i5;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/bank_mode_ctrl.sv
module bank_mode_ctrl
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpsr_we,
    input  logic [DATA_W-1:0] cpsr_wdata,
    output logic [DATA_W-1:0] cpsr_q,
    output bank_e             bank_q,
    output logic              cur_has_saved,
    output logic [SLOT_W-1:0] cur_slot
);

    localparam logic [DATA_W-1:0] RST_STATUS = DATA_W'(MODE_SVC);

    bank_e bank_d;

    // Next-state: any status write re-decodes the mode field.
    always_comb begin
        bank_d = bank_q;
        if (cpsr_we) begin
            bank_d = decode_bank(cpsr_wdata[MODE_W-1:0]);
        end
    end

    // State register and status word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= BANK_SVC;
            cpsr_q <= RST_STATUS;
        end else begin
            bank_q <= bank_d;
            if (cpsr_we) begin
                cpsr_q <= cpsr_wdata;
            end
        end
    end

    // Outputs of the current state.
    always_comb begin
        unique case (bank_q)
            BANK_USR: begin cur_has_saved = 1'b0; cur_slot = '0; end
            BANK_FIQ: begin cur_has_saved = 1'b1; cur_slot = slot_of(BANK_FIQ); end
            BANK_IRQ: begin cur_has_saved = 1'b1; cur_slot = slot_of(BANK_IRQ); end
            BANK_SVC: begin cur_has_saved = 1'b1; cur_slot = slot_of(BANK_SVC); end
            BANK_ABT: begin cur_has_saved = 1'b1; cur_slot = slot_of(BANK_ABT); end
            BANK_UND: begin cur_has_saved = 1'b1; cur_slot = slot_of(BANK_UND); end
            default:  begin cur_has_saved = 1'b0; cur_slot = '0; end
        endcase
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_pkg::*;
(
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    output logic [PHYS_W-1:0] phys,
    output logic              is_pc
);

    always_comb begin
        phys  = phys_of(bank, idx);
        is_pc = (idx == PC_IDX);
    end

endmodule

// File: rtl/gpr_store.sv
module gpr_store
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [PHYS_W-1:0]             wr_phys,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_RD-1:0][PHYS_W-1:0] rd_phys,
    input  logic [NUM_RD-1:0]             rd_is_pc,
    input  logic [DATA_W-1:0]             pc_off,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs [NUM_PHYS];

    for (genvar g = 0; g < NUM_PHYS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && wr_phys == PHYS_W'(g)) begin
                regs[g] <= wr_data;
            end
        end
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        logic [DATA_W-1:0] raw;
        always_comb begin
            if (wr_en && wr_phys == rd_phys[r]) begin
                raw = wr_data;
            end else begin
                raw = regs[rd_phys[r]];
            end
            rd_data[r] = rd_is_pc[r] ? raw + pc_off : raw;
        end
    end

endmodule

// File: rtl/psr_bank.sv
module psr_bank
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cpsr_q,
    input  logic              snap_en,
    input  logic [SLOT_W-1:0] snap_slot,
    input  logic              cur_valid,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] saved [NUM_SAVED];
    logic              snap_hits_cur;
    logic              wr_live;

    always_comb begin
        snap_hits_cur = snap_en && cur_valid && (snap_slot == cur_slot);
        wr_live       = wr_en && cur_valid && !snap_hits_cur;
    end

    for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                saved[s] <= '0;
            end else if (snap_en && snap_slot == SLOT_W'(s)) begin
                saved[s] <= cpsr_q;
            end else if (wr_live && cur_slot == SLOT_W'(s)) begin
                saved[s] <= wr_data;
            end
        end
    end

    always_comb begin
        if (!cur_valid) begin
            rd_data = '0;
        end else if (snap_hits_cur) begin
            rd_data = cpsr_q;
        end else if (wr_en) begin
            rd_data = wr_data;
        end else begin
            rd_data = saved[cur_slot];
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] pc_offset,
    input  logic              cpsr_we,
    input  logic [DATA_W-1:0] cpsr_wdata,
    output logic [DATA_W-1:0] cpsr_q,
    input  logic              spsr_we,
    input  logic [DATA_W-1:0] spsr_wdata,
    output logic [DATA_W-1:0] spsr_rdata,
    input  logic              exc_enter,
    input  logic [4:0]        exc_mode
);

    localparam int NUM_MAP = NUM_RD + 1;

    bank_e                         bank_q;
    logic                          cur_has_saved;
    logic [SLOT_W-1:0]             cur_slot;
    logic [NUM_MAP-1:0][IDX_W-1:0] map_idx;
    logic [NUM_MAP-1:0][PHYS_W-1:0] map_phys;
    logic [NUM_MAP-1:0]            map_pc;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
    bank_e                         exc_bank;
    logic                          snap_en;
    logic [SLOT_W-1:0]             snap_slot;
    logic                          wr_pc_unused;

    bank_mode_ctrl #(.DATA_W(DATA_W)) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpsr_we       (cpsr_we),
        .cpsr_wdata    (cpsr_wdata),
        .cpsr_q        (cpsr_q),
        .bank_q        (bank_q),
        .cur_has_saved (cur_has_saved),
        .cur_slot      (cur_slot)
    );

    // Port 0 and 1 are reads, the last one is the write port.
    always_comb begin
        map_idx[0]       = rd_a_idx;
        map_idx[1]       = rd_b_idx;
        map_idx[NUM_RD]  = wr_idx;
    end

    for (genvar m = 0; m < NUM_MAP; m++) begin : g_map
        bank_mapper u_map (
            .bank  (bank_q),
            .idx   (map_idx[m]),
            .phys  (map_phys[m]),
            .is_pc (map_pc[m])
        );
    end

    assign wr_pc_unused = map_pc[NUM_RD];

    gpr_store #(.DATA_W(DATA_W)) u_gpr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_phys  (map_phys[NUM_RD]),
        .wr_data  (wr_data),
        .rd_phys  (map_phys[NUM_RD-1:0]),
        .rd_is_pc (map_pc[NUM_RD-1:0]),
        .pc_off   (pc_offset),
        .rd_data  (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    always_comb begin
        exc_bank  = decode_bank(exc_mode);
        snap_en   = exc_enter && has_saved(exc_bank);
        snap_slot = slot_of(exc_bank);
    end

    psr_bank #(.DATA_W(DATA_W)) u_psr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpsr_q    (cpsr_q),
        .snap_en   (snap_en),
        .snap_slot (snap_slot),
        .cur_valid (cur_has_saved),
        .cur_slot  (cur_slot),
        .wr_en     (spsr_we),
        .wr_data   (spsr_wdata),
        .rd_data   (spsr_rdata)
    );

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              cpsr_we,
    input logic [DATA_W-1:0] cpsr_wdata,
    input logic [DATA_W-1:0] cpsr_q,
    input logic              spsr_we,
    input logic [DATA_W-1:0] spsr_rdata,
    input logic              exc_enter,
    input logic [4:0]        exc_mode
);

    function automatic logic is_exc(input logic [4:0] m);
        return (m == 5'b10001) || (m == 5'b10010) || (m == 5'b10011) ||
               (m == 5'b10111) || (m == 5'b11011);
    endfunction

    // R10: status word loads on the next edge.
    assert_status_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_we |=> cpsr_q == $past(cpsr_wdata));

    // R9: same-cycle write to the same index is forwarded (non-PC).
    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == rd_a_idx && rd_a_idx != 4'd15) |-> rd_a_data == wr_data);

    // R7: modes without a saved-status register read zero.
    assert_no_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_exc(cpsr_q[4:0]) |-> spsr_rdata == '0);

    // R8: entering an exception mode saves the old status word.
    assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && is_exc(exc_mode) && cpsr_we && cpsr_wdata[4:0] == exc_mode)
        |=> (spsr_we || exc_enter || spsr_rdata == $past(cpsr_q)));

    // R11: both read ports agree on the same index.
    assert_ports_agree_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cpsr_we    (cpsr_we),
    .cpsr_wdata (cpsr_wdata),
    .cpsr_q     (cpsr_q),
    .spsr_we    (spsr_we),
    .spsr_rdata (spsr_rdata),
    .exc_enter  (exc_enter),
    .exc_mode   (exc_mode)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, cpsr_q, spsr_rdata;
    logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0, exc_enter = 1'b0;
    logic [31:0] wr_data = '0, pc_offset = '0, cpsr_wdata = '0, spsr_wdata = '0;
    logic [4:0]  exc_mode = '0;

    int checks = 0;
    int errors = 0;
    string tag_ovr = "";

    logic [31:0] m_gpr [31];
    logic [31:0] m_cpsr;
    logic [31:0] m_saved [5];

    always #2 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_offset(pc_offset),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_q(cpsr_q),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata),
        .exc_enter(exc_enter), .exc_mode(exc_mode)
    );

    // 0 user/system/other, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
    function automatic int f_bank(input logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int f_phys(input int b, input int idx);
        if (idx < 8 || idx == 15) return idx;
        if (b == 1) return 16 + idx - 8;
        if (idx < 13) return idx;
        case (b)
            3: return 23 + idx - 13;
            4: return 25 + idx - 13;
            2: return 27 + idx - 13;
            5: return 29 + idx - 13;
            default: return idx;
        endcase
    endfunction

    function automatic logic [4:0] f_pick_mode(input int k);
        case (k % 8)
            0: return 5'b10000;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10011;
            4: return 5'b10111;
            5: return 5'b11011;
            6: return 5'b11111;
            default: return 5'b00101;
        endcase
    endfunction

    function automatic string f_rd_tag(input int idx, input logic byp);
        if (tag_ovr != "") return tag_ovr;
        if (byp) return "R9";
        if (idx == 15) return "R5";
        if (idx < 8) return "R2";
        if (idx < 13) return "R3";
        return "R4";
    endfunction

    function automatic logic [31:0] f_rd(input int idx, output logic byp);
        int b = f_bank(m_cpsr[4:0]);
        int p = f_phys(b, idx);
        logic [31:0] v;
        byp = wr_en && (f_phys(b, int'(wr_idx)) == p);
        v = byp ? wr_data : m_gpr[p];
        if (idx == 15) v = v + pc_offset;
        return v;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cycle();
        logic byp;
        logic [31:0] e;
        int b, cs, xb;
        string t;
        #1;
        e = f_rd(int'(rd_a_idx), byp);
        chk(f_rd_tag(int'(rd_a_idx), byp), "port A", rd_a_data, e);
        e = f_rd(int'(rd_b_idx), byp);
        chk(f_rd_tag(int'(rd_b_idx), byp), "port B", rd_b_data, e);
        chk(tag_ovr != "" ? tag_ovr : "R10", "status", cpsr_q, m_cpsr);
        b  = f_bank(m_cpsr[4:0]);
        xb = f_bank(exc_mode);
        cs = b - 1;
        if (b == 0) begin
            e = '0; t = "R7";
        end else if (exc_enter && xb == b) begin
            e = m_cpsr; t = "R8";
        end else if (spsr_we) begin
            e = spsr_wdata; t = "R9";
        end else begin
            e = m_saved[cs]; t = "R6";
        end
        chk(tag_ovr != "" ? tag_ovr : t, "saved status", spsr_rdata, e);
        @(posedge clk);
        if (wr_en) m_gpr[f_phys(b, int'(wr_idx))] = wr_data;
        if (exc_enter && xb != 0) m_saved[xb - 1] = m_cpsr;
        if (spsr_we && b != 0 && !(exc_enter && xb == b)) m_saved[cs] = spsr_wdata;
        if (cpsr_we) m_cpsr = cpsr_wdata;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; cpsr_we = 0; spsr_we = 0; exc_enter = 0;
    endtask

    task automatic set_mode(input logic [4:0] m);
        idle(); cpsr_we = 1; cpsr_wdata = {27'h0, m}; cycle(); idle();
    endtask

    task automatic gwrite(input logic [3:0] i, input logic [31:0] d);
        idle(); wr_en = 1; wr_idx = i; wr_data = d; cycle(); idle();
    endtask

    task automatic readpair(input logic [3:0] a, input logic [3:0] b);
        idle(); rd_a_idx = a; rd_b_idx = b; cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 31; i++) m_gpr[i] = '0;
        for (int i = 0; i < 5; i++) m_saved[i] = '0;
        m_cpsr = 32'h13;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset contents
        tag_ovr = "R1";
        for (int i = 0; i < 16; i++) readpair(4'(i), 4'(15 - i));
        tag_ovr = "";

        // R10 / R4: write in the cycle the mode changes lands in the old bank
        gwrite(4'd13, 32'hAAAA_0013);
        idle(); cpsr_we = 1; cpsr_wdata = 32'h10; wr_en = 1; wr_idx = 4'd14;
        wr_data = 32'hBBBB_0014; cycle(); idle();
        tag_ovr = "R4"; readpair(4'd13, 4'd14);
        set_mode(5'b10011); readpair(4'd13, 4'd14);
        set_mode(5'b00101); readpair(4'd13, 4'd14); tag_ovr = "";

        // R3: fast-interrupt high registers are private
        set_mode(5'b10001);
        gwrite(4'd8, 32'hF8F8_F8F8); gwrite(4'd12, 32'hFCFC_0000); gwrite(4'd13, 32'h1313_F1F1);
        tag_ovr = "R3"; readpair(4'd8, 4'd12);
        set_mode(5'b10010); readpair(4'd8, 4'd12);
        gwrite(4'd9, 32'h0909_0909);
        set_mode(5'b10001); readpair(4'd9, 4'd13); tag_ovr = "";

        // R2: low registers shared
        gwrite(4'd3, 32'h3333_1111);
        set_mode(5'b11111);
        tag_ovr = "R2"; readpair(4'd3, 4'd3); tag_ovr = "";

        // R5 / R9: PC write and bypass with offset
        pc_offset = 32'd8; gwrite(4'd15, 32'h0000_1000);
        tag_ovr = "R5"; readpair(4'd15, 4'd0);
        pc_offset = 32'd4; wr_en = 1; wr_idx = 4'd15; wr_data = 32'hFFFF_FFFE;
        rd_a_idx = 4'd15; cycle(); idle(); tag_ovr = "";

        // R8: snapshot with a status write and a saved-status write at once
        set_mode(5'b10000);
        cpsr_we = 1; cpsr_wdata = 32'hA000_0010; cycle(); idle();
        exc_enter = 1; exc_mode = 5'b10010; cpsr_we = 1; cpsr_wdata = 32'h0000_0092;
        spsr_we = 1; spsr_wdata = 32'hDEAD_BEEF;
        tag_ovr = "R8"; cycle(); idle(); readpair(4'd0, 4'd1);
        exc_enter = 1; exc_mode = 5'b10010; spsr_we = 1; spsr_wdata = 32'h1234_5678;
        cycle(); idle(); readpair(4'd0, 4'd1);
        exc_enter = 1; exc_mode = 5'b11111; cycle(); idle(); readpair(4'd0, 4'd1);
        tag_ovr = "";

        // R6: explicit saved-status write
        spsr_we = 1; spsr_wdata = 32'h0F0F_0F0F; tag_ovr = "R6"; cycle(); idle();
        readpair(4'd2, 4'd2); tag_ovr = "";

        // R7: saved-status write in user mode is ignored
        set_mode(5'b10000);
        spsr_we = 1; spsr_wdata = 32'h7777_7777; tag_ovr = "R7"; cycle(); idle();
        readpair(4'd0, 4'd0);
        set_mode(5'b10010); readpair(4'd0, 4'd0); tag_ovr = "";

        // R11: independent ports
        gwrite(4'd5, 32'h5555_AAAA); gwrite(4'd6, 32'h6666_BBBB);
        tag_ovr = "R11"; readpair(4'd5, 4'd6); readpair(4'd6, 4'd5); tag_ovr = "";

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int k;
            rd_a_idx  = 4'($urandom % 16);
            rd_b_idx  = 4'($urandom % 16);
            wr_en     = ($urandom % 2) == 0;
            wr_idx    = 4'($urandom % 16);
            wr_data   = $urandom;
            pc_offset = (($urandom % 2) == 0) ? 32'd4 : 32'd8;
            k         = int'($urandom % 8);
            cpsr_we   = ($urandom % 6) == 0;
            cpsr_wdata = {$urandom, 5'b0} | {27'h0, f_pick_mode(k)};
            spsr_we   = ($urandom % 4) == 0;
            spsr_wdata = $urandom;
            exc_enter = ($urandom % 8) == 0;
            exc_mode  = f_pick_mode(int'($urandom % 8));
            if (exc_enter && ($urandom % 2) == 0) begin
                cpsr_we = 1;
                cpsr_wdata = {cpsr_wdata[31:5], exc_mode};
            end
            cycle();
        end
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule